// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether the receive side of a 10BASE-T twisted-pair link is alive. It watches two indications from the receive path. One is a level flag that is high while a data frame is arriving. The other is a one-cycle strobe for each link pulse that the receive path has already qualified. Silence for too long moves the block into a failure state. While it is failed, it tells the surrounding transceiver to stop transmitting, stop delivering received data, and stop the normal loopback path. The link is declared good again after one data frame, or after a counted number of link pulses that arrive inside the allowed interval window.

The block also paces the link pulses that this end sends. While link testing is enabled, the transmitter has no data to send and forced loopback is off, it raises a one-cycle request at a fixed period. A transmit stage beside it turns each request into a pulse on the line.

All timing is in clock ticks and set by parameters. The ports are plain control and status levels or strobes, so none of them uses a valid/ready handshake.

Top module: `link_watch`

## Requirements
- R1: With testing enabled and no refresh, `link_ok_o` stays high for at least LOSS_TICKS-3 cycles after the last refresh and is low by LOSS_TICKS+1 cycles after it.
- R2: In the good state, a data frame refreshes the loss timer, and so does a link pulse arriving at least MIN_TICKS cycles after the last refresh. An earlier pulse does not refresh it.
- R3: Whenever the link is failed with testing enabled, `tx_block_o`, `rx_block_o` and `lpbk_block_o` are all high. In the good state all three are low.
- R4: In the fail-reset, fail-wait or interval state, a cycle with `rx_frame_i` high makes `link_ok_o` high on the next cycle.
- R5: From the failed state, the link becomes good only after PULSES_NEEDED (default 2) accepted pulses. Fewer pulses leave it failed. Entering failure clears the count.
- R6: In the interval state, a pulse that arrives before MIN_TICKS cycles have elapsed moves the block to the extended-fail state. That state drops the pulse count. It returns to fail-reset only once the line is quiet and `tx_busy_i` is low.
- R7: If no pulse arrives within MAX_TICKS cycles in the interval state, the block enters extended-fail and the pulses counted so far are lost.
- R8: With testing enabled, `tx_busy_i` low and `force_lpbk_i` low, `pulse_req_o` is a one-cycle strobe every PERIOD_TICKS cycles. The first strobe is visible PERIOD_TICKS cycles after the condition starts.
- R9: With `test_en_i` low, `link_ok_o` is high, the three disables are low, and no pulse is requested.
- R10: While `tx_busy_i` or `force_lpbk_i` is high, `pulse_req_o` stays low.
- R11: After reset, the link is good, the disables are low and `pulse_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en_i | input | 1 | Enables link integrity testing |
| rx_frame_i | input | 1 | High while a receive data frame is in progress |
| pulse_seen_i | input | 1 | One-cycle strobe per qualified received link pulse |
| tx_busy_i | input | 1 | High while transmit data is active |
| force_lpbk_i | input | 1 | Forced internal loopback; suppresses pulse requests |
| link_ok_o | output | 1 | Link judged good |
| tx_block_o | output | 1 | Disable transmit |
| rx_block_o | output | 1 | Disable receive data delivery |
| lpbk_block_o | output | 1 | Disable normal loopback |
| pulse_req_o | output | 1 | One-cycle request to send a link pulse |

## Verification
The bench builds the block with LOSS_TICKS=60, MIN_TICKS=8, MAX_TICKS=40, PERIOD_TICKS=12 and PULSES_NEEDED=2. These tick counts are far below the real millisecond values. With them, loss of link, recovery, the extended-fail path and both ends of the interval window each take a few dozen cycles. Several pulse periods fit inside one short observation window. The chosen gaps put pulses well inside or well outside the minimum and maximum limits, and close to the loss deadline, so a timer that is off by a few ticks changes the observed link state.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [2:0] {
    ST_GOOD   = 3'd0,
    ST_RESET  = 3'd1,
    ST_SPAN   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_EXT    = 3'd4
  } link_st_e;
endpackage

// File: rtl/lt_tick_timer.sv
module lt_tick_timer #(
  parameter int LIMIT = 100,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_o <= '0;
    else if (clr_i)      cnt_o <= '0;
    else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  AST_TMR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= TOP); // R1
endmodule

// File: rtl/lt_link_fsm.sv
module lt_link_fsm
  import lt_pkg::*;
#(
  parameter int LOSS_TICKS    = 60,
  parameter int MIN_TICKS     = 8,
  parameter int MAX_TICKS     = 40,
  parameter int PULSES_NEEDED = 2,
  parameter int TW            = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          rx_frame_i,
  input  logic          pulse_i,
  input  logic          tx_busy_i,
  input  logic [TW-1:0] tmr_i,
  output logic          tmr_clr_o,
  output logic          link_ok_o,
  output logic          failed_o
);
  localparam int CW = $clog2(PULSES_NEEDED + 1);
  localparam logic [TW-1:0] LOSS_M1 = TW'(LOSS_TICKS - 1);
  localparam logic [TW-1:0] MIN_T   = TW'(MIN_TICKS);
  localparam logic [TW-1:0] MAX_T   = TW'(MAX_TICKS);
  localparam logic [CW-1:0] NEED    = CW'(PULSES_NEEDED);

  link_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic spaced, refresh;

  assign spaced  = pulse_i && (tmr_i >= MIN_T);
  assign refresh = rx_frame_i || spaced;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_GOOD:   if (!refresh && tmr_i >= LOSS_M1) st_d = ST_RESET;
      ST_RESET: begin
        cnt_d = '0;
        if (rx_frame_i)    st_d = ST_GOOD;
        else if (!pulse_i) st_d = ST_SPAN;
      end
      ST_SPAN: begin
        if (rx_frame_i) st_d = ST_GOOD;
        else if (pulse_i) begin
          if (spaced) begin
            st_d  = ST_SETTLE;
            if (cnt_q != NEED) cnt_d = cnt_q + 1'b1;
          end else begin
            st_d = ST_EXT;
          end
        end else if (tmr_i >= MAX_T) st_d = ST_EXT;
      end
      ST_SETTLE: begin
        if (rx_frame_i) st_d = ST_GOOD;
        else if (!pulse_i) st_d = (cnt_q >= NEED) ? ST_GOOD : ST_SPAN;
      end
      ST_EXT: begin
        cnt_d = '0;
        if (!rx_frame_i && !pulse_i && !tx_busy_i) st_d = ST_RESET;
      end
      default:   st_d = ST_RESET;
    endcase
    if (!en_i) begin
      st_d  = ST_GOOD;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_GOOD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign tmr_clr_o = !en_i || (st_d != st_q) || (st_q == ST_GOOD && refresh);
  assign failed_o  = en_i && (st_q != ST_GOOD);
  assign link_ok_o = !failed_o;

  AST_FRAME_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rx_frame_i && (st_q == ST_RESET || st_q == ST_SPAN || st_q == ST_SETTLE))
      |=> (st_q == ST_GOOD)); // R4
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NEED); // R5
  AST_CLOSE_PULSE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st_q == ST_SPAN && !rx_frame_i && pulse_i && tmr_i < MIN_T)
      |=> (st_q == ST_EXT)); // R6
  AST_DISABLED_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == ST_GOOD)); // R9
endmodule

// File: rtl/lt_pulse_pacer.sv
module lt_pulse_pacer #(
  parameter int PERIOD_TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tx_busy_i,
  input  logic force_lpbk_i,
  output logic req_o
);
  localparam int PW = $clog2(PERIOD_TICKS);
  localparam logic [PW-1:0] LAST = PW'(PERIOD_TICKS - 1);

  logic [PW-1:0] cnt_q;
  logic          run;

  assign run = en_i && !tx_busy_i && !force_lpbk_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else begin
      req_o <= run && (cnt_q == LAST);
      if (!run || cnt_q == LAST) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || tx_busy_i || force_lpbk_i) |=> !req_o); // R10
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o); // R8
endmodule

// File: rtl/link_watch.sv
module link_watch #(
  parameter int LOSS_TICKS    = 60,
  parameter int MIN_TICKS     = 8,
  parameter int MAX_TICKS     = 40,
  parameter int PERIOD_TICKS  = 12,
  parameter int PULSES_NEEDED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en_i,
  input  logic rx_frame_i,
  input  logic pulse_seen_i,
  input  logic tx_busy_i,
  input  logic force_lpbk_i,
  output logic link_ok_o,
  output logic tx_block_o,
  output logic rx_block_o,
  output logic lpbk_block_o,
  output logic pulse_req_o
);
  localparam int TLIM = (LOSS_TICKS > MAX_TICKS) ? LOSS_TICKS : MAX_TICKS;
  localparam int TW   = $clog2(TLIM + 1);

  logic [TW-1:0] tmr;
  logic          tmr_clr, failed;

  lt_tick_timer #(.LIMIT(TLIM)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .cnt_o(tmr)
  );

  lt_link_fsm #(
    .LOSS_TICKS(LOSS_TICKS), .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS),
    .PULSES_NEEDED(PULSES_NEEDED), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(test_en_i), .rx_frame_i(rx_frame_i),
    .pulse_i(pulse_seen_i), .tx_busy_i(tx_busy_i), .tmr_i(tmr),
    .tmr_clr_o(tmr_clr), .link_ok_o(link_ok_o), .failed_o(failed)
  );

  lt_pulse_pacer #(.PERIOD_TICKS(PERIOD_TICKS)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en_i(test_en_i), .tx_busy_i(tx_busy_i),
    .force_lpbk_i(force_lpbk_i), .req_o(pulse_req_o)
  );

  assign tx_block_o   = failed;
  assign rx_block_o   = failed;
  assign lpbk_block_o = failed;

  AST_DISABLES_WITH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok_o |-> (tx_block_o && rx_block_o && lpbk_block_o)); // R3
  AST_LOSS_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok_o && rx_frame_i) |=> link_ok_o); // R2
endmodule

// File: tb/link_watch_tb_top.sv
module link_watch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS = 60, MINT = 8, MAXT = 40, PER = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, rxf = 1'b0, pls = 1'b0, busy = 1'b0, lpbk = 1'b0;
  logic ok, txb, rxb, lbb, req;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_watch #(.LOSS_TICKS(LOSS), .MIN_TICKS(MINT), .MAX_TICKS(MAXT),
               .PERIOD_TICKS(PER), .PULSES_NEEDED(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_en_i(en), .rx_frame_i(rxf),
    .pulse_seen_i(pls), .tx_busy_i(busy), .force_lpbk_i(lpbk),
    .link_ok_o(ok), .tx_block_o(txb), .rx_block_o(rxb), .lpbk_block_o(lbb),
    .pulse_req_o(req)
  );

  // {en, busy, lpbk, strobes in 48 cycles [2:0], link_ok}
  localparam logic [6:0] VEC [5] = '{
    {3'b100, 3'd4, 1'b1},   // R8 free running
    {3'b110, 3'd0, 1'b1},   // R10 transmit busy
    {3'b101, 3'd0, 1'b1},   // R10 forced loopback
    {3'b000, 3'd0, 1'b1},   // R9 disabled
    {3'b111, 3'd0, 1'b1}    // R10 both
  };

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit e);
    @(negedge clk);
    rst_n = 1'b0; en = e; rxf = 1'b0; pls = 1'b0; busy = 1'b0; lpbk = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse();
    pls = 1'b1; cyc(1); pls = 1'b0;
  endtask

  task automatic go_fail();
    do_reset(1'b1);
    cyc(LOSS + 5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset(1'b1);
    chk(ok === 1'b1, "R11 link_ok after reset", ok, 1);
    chk({txb, rxb, lbb} === 3'b000, "R11 disables after reset", {txb, rxb, lbb}, 0);
    chk(req === 1'b0, "R11 pulse_req after reset", req, 0);

    // table of request pacing and enable patterns
    foreach (VEC[i]) begin
      int seen;
      do_reset(VEC[i][6]);
      busy = VEC[i][5]; lpbk = VEC[i][4];
      seen = 0;
      for (int k = 0; k < 48; k++) begin
        cyc(1);
        if (req === 1'b1) seen++;
      end
      chk(seen == int'(VEC[i][3:1]), "R8/R10 request count", seen, VEC[i][3:1]);
      chk(ok === VEC[i][0], "R9 link_ok in table", ok, VEC[i][0]);
    end

    // R9 disabled for a long quiet period
    do_reset(1'b0);
    cyc(3 * LOSS);
    chk(ok === 1'b1, "R9 link held good when disabled", ok, 1);
    chk(txb === 1'b0, "R9 tx disable low when disabled", txb, 0);

    // R1 loss timing and R3 disables
    do_reset(1'b1);
    cyc(LOSS - 3);
    chk(ok === 1'b1, "R1 still good before loss time", ok, 1);
    cyc(5);
    chk(ok === 1'b0, "R1 failed after loss time", ok, 0);
    chk({txb, rxb, lbb} === 3'b111, "R3 all disables in fail", {txb, rxb, lbb}, 7);

    // R2 spaced pulses keep the link alive
    do_reset(1'b1);
    for (int k = 0; k < 8; k++) begin cyc(20); pulse(); end
    chk(ok === 1'b1, "R2 spaced pulses refresh", ok, 1);

    // R2 a pulse too soon after a frame does not refresh
    do_reset(1'b1);
    cyc(10);
    rxf = 1'b1; cyc(1); rxf = 1'b0;
    cyc(2); pulse();
    cyc(LOSS - 2);
    chk(ok === 1'b0, "R2 early pulse ignored in good state", ok, 0);

    // R4 frame recovery
    go_fail();
    rxf = 1'b1; cyc(1); rxf = 1'b0;
    chk(ok === 1'b1, "R4 frame restores link", ok, 1);

    // R5 two spaced pulses needed
    go_fail();
    cyc(12); pulse();
    cyc(3);
    chk(ok === 1'b0, "R5 one pulse not enough", ok, 0);
    cyc(10); pulse();
    cyc(3);
    chk(ok === 1'b1, "R5 two pulses restore link", ok, 1);

    // R6 too-close pulse restarts counting
    go_fail();
    cyc(12); pulse();
    cyc(3); pulse();
    cyc(15); pulse();
    cyc(3);
    chk(ok === 1'b0, "R6 close pulse dropped count", ok, 0);
    cyc(12); pulse();
    cyc(3);
    chk(ok === 1'b1, "R6 recovers after fresh pair", ok, 1);

    // R6 extended fail held while transmit busy
    go_fail();
    cyc(12); pulse();
    cyc(3); busy = 1'b1; pulse();
    cyc(30); pulse();
    cyc(20); pulse();
    cyc(3);
    chk(ok === 1'b0, "R6 stays failed while transmit busy", ok, 0);

    // R7 maximum interval loses count
    busy = 1'b0;
    go_fail();
    cyc(12); pulse();
    cyc(60); pulse();
    cyc(3);
    chk(ok === 1'b0, "R7 late pulse after max restarts count", ok, 0);
    cyc(12); pulse();
    cyc(3);
    chk(ok === 1'b1, "R7 recovers after next spaced pulse", ok, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule